// File: doc/BRIEF.md
# Big-Endian Byte-Lane Steering Unit

This block sits between a 32-bit processor datapath and a byte-addressed 32-bit data memory. It handles byte, halfword and word accesses. On the store side it takes the effective address, the access size and the register value. It returns the 32-bit word to write and a 4-bit byte-enable mask that marks which memory bytes change. On the load side it takes the same address and size, the word read from memory and a flag that selects zero extension. It returns the addressed byte, halfword or word, widened to 32 bits.

Lane order is big endian: the byte at the lowest address within a word travels on bits 31:24. An access whose address does not fit its size raises a misalignment flag. A misaligned store then enables no byte, and a misaligned load returns zero. Both paths are purely combinational. Load data is ready in the same cycle as the memory read word, and store data is ready in the same cycle as the address. The block has no clock and no state, so no handshake or back-pressure applies at either edge: every output follows its inputs directly.

Top module: `be_lane_unit`

## Requirements
- R1: `misalign_o` is 1 in three cases: a halfword access (size code 01) with address bit 0 set, a word access (size code 10) whose address bits 1:0 are not 00, and any access with the reserved size code 11. A byte access (size code 00) never sets it.
- R2: An aligned byte store enables exactly one lane. Offset k (address bits 1:0) sets enable bit 3-k, so offset 0 sets bit 3, which controls data bits 31:24.
- R3: An aligned halfword store enables 4'b1100 at offset 0 and 4'b0011 at offset 2. An aligned word store enables 4'b1111.
- R4: Any misaligned store drives the enable mask to 4'b0000.
- R5: The write word does not depend on the address. For a byte store it is bits 7:0 of the register repeated in all four lanes. For a halfword store it is bits 15:0 repeated in both halves. For a word store it is the whole register. Register bits above the access size have no effect on what is written.
- R6: A byte load at offset k selects read-data bits [31-8k : 24-8k].
- R7: A halfword load selects read-data bits 31:16 at offset 0 and bits 15:0 at offset 2.
- R8: An aligned word load returns the read word unchanged, whatever the value of the zero-extension flag.
- R9: With `zero_ext_i` = 0, byte and halfword loads copy the top bit of the selected value into every higher bit of the result.
- R10: With `zero_ext_i` = 1, byte and halfword loads clear every bit of the result above the selected value.
- R11: A misaligned load drives `load_data_o` to zero.
- R12: Address bits above bit 1 have no effect on any output. Every output follows its inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | ADDR_W | Effective byte address |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| zero_ext_i | input | 1 | 1 selects zero extension for narrow loads, 0 selects sign extension |
| store_data_i | input | 32 | Register value to store |
| mem_wdata_o | output | 32 | Write word with the value placed in its lanes |
| mem_be_o | output | 4 | Byte enables; bit 3 is the lane at offset 0 (bits 31:24) |
| mem_rdata_i | input | 32 | Word read from memory |
| load_data_o | output | 32 | Selected and extended load result |
| misalign_o | output | 1 | Access address does not fit the access size |

## Verification
The bench builds the unit with ADDR_W = 6. With that width it can sweep all 64 addresses against all four size codes, for both stores and loads. That sweep covers every lane offset together with every combination of the upper address bits, so R12 is checked everywhere and not just at a few points. Read patterns whose selected lanes have the top bit set and clear exercise both extension modes. A final step changes only the read word and samples the result in that same cycle, with no clock edge in between.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int OFF_W  = $clog2(LANES);
  localparam int HALVES = LANES / 2;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
  import be_lane_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  output logic             misalign_o
);
  always_comb begin
    unique case (size_i)
      ACC_BYTE: misalign_o = 1'b0;
      ACC_HALF: misalign_o = off_i[0];
      ACC_WORD: misalign_o = |off_i;
      default:  misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer
  import be_lane_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  acc_size_e         size_i,
  input  logic              misalign_i,
  input  logic [WORD_W-1:0] src_i,
  output logic [WORD_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int BOFF = LANES - 1 - g;
    logic hit;
    logic [BYTE_W-1:0] lane_val;

    always_comb begin
      unique case (size_i)
        ACC_BYTE: hit = (off_i == OFF_W'(BOFF));
        ACC_HALF: hit = (off_i[OFF_W-1:1] == (OFF_W-1)'(BOFF / 2));
        ACC_WORD: hit = 1'b1;
        default:  hit = 1'b0;
      endcase
    end

    always_comb begin
      unique case (size_i)
        ACC_BYTE: lane_val = src_i[BYTE_W-1:0];
        ACC_HALF: lane_val = src_i[(g % 2)*BYTE_W +: BYTE_W];
        default:  lane_val = src_i[g*BYTE_W +: BYTE_W];
      endcase
    end

    assign be_o[g] = hit & ~misalign_i;
    assign wdata_o[g*BYTE_W +: BYTE_W] = lane_val;
  end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import be_lane_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  acc_size_e         size_i,
  input  logic              misalign_i,
  input  logic              zero_ext_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] result_o
);
  logic [BYTE_W-1:0] byte_sel;
  logic [HALF_W-1:0] half_sel;

  always_comb begin
    byte_sel = '0;
    for (int i = 0; i < LANES; i++) begin
      if (off_i == OFF_W'(LANES - 1 - i)) byte_sel = rdata_i[i*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    half_sel = '0;
    for (int j = 0; j < HALVES; j++) begin
      if (off_i[OFF_W-1:1] == (OFF_W-1)'(HALVES - 1 - j)) half_sel = rdata_i[j*HALF_W +: HALF_W];
    end
  end

  always_comb begin
    if (misalign_i) begin
      result_o = '0;
    end else begin
      unique case (size_i)
        ACC_BYTE: result_o = {{(WORD_W-BYTE_W){~zero_ext_i & byte_sel[BYTE_W-1]}}, byte_sel};
        ACC_HALF: result_o = {{(WORD_W-HALF_W){~zero_ext_i & half_sel[HALF_W-1]}}, half_sel};
        default:  result_o = rdata_i;
      endcase
    end
  end
endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
  import be_lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              zero_ext_i,
  input  logic [31:0]       store_data_i,
  output logic [31:0]       mem_wdata_o,
  output logic [3:0]        mem_be_o,
  input  logic [31:0]       mem_rdata_i,
  output logic [31:0]       load_data_o,
  output logic              misalign_o
);
  logic [OFF_W-1:0] off;
  acc_size_e        sz;

  assign off = addr_i[OFF_W-1:0];
  assign sz  = acc_size_e'(size_i);

  lane_align_check u_align (
    .off_i      (off),
    .size_i     (sz),
    .misalign_o (misalign_o)
  );

  lane_store_steer u_store (
    .off_i      (off),
    .size_i     (sz),
    .misalign_i (misalign_o),
    .src_i      (store_data_i),
    .wdata_o    (mem_wdata_o),
    .be_o       (mem_be_o)
  );

  lane_load_extract u_load (
    .off_i      (off),
    .size_i     (sz),
    .misalign_i (misalign_o),
    .zero_ext_i (zero_ext_i),
    .rdata_i    (mem_rdata_i),
    .result_o   (load_data_o)
  );
endmodule

// File: rtl/be_lane_unit_chk.sv
module be_lane_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              zero_ext_i,
  input logic [31:0]       store_data_i,
  input logic [31:0]       mem_wdata_o,
  input logic [3:0]        mem_be_o,
  input logic [31:0]       load_data_o,
  input logic              misalign_o
);
  always_comb begin
    if (size_i == 2'b00)
      a_r1_byte_never_misaligned: assert (!misalign_o) else $error("byte access flagged misaligned");
    if (misalign_o)
      a_r4_misaligned_no_enable: assert (mem_be_o == 4'b0000) else $error("misaligned store enables lanes");
    if (size_i == 2'b00)
      a_r2_byte_one_lane: assert ($countones(mem_be_o) == 1) else $error("byte store lane count");
    if (size_i == 2'b01 && !misalign_o)
      a_r3_half_two_lanes: assert ($countones(mem_be_o) == 2) else $error("halfword store lane count");
    if (misalign_o)
      a_r11_misaligned_load_zero: assert (load_data_o == 32'd0) else $error("misaligned load nonzero");
    if (size_i == 2'b00 && zero_ext_i)
      a_r10_byte_upper_clear: assert (load_data_o[31:8] == 24'd0) else $error("zero extension broken");
    if (size_i == 2'b10)
      a_r5_word_store_whole: assert (mem_wdata_o == store_data_i) else $error("word store data altered");
  end
endmodule

bind be_lane_unit be_lane_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .addr_i       (addr_i),
  .size_i       (size_i),
  .zero_ext_i   (zero_ext_i),
  .store_data_i (store_data_i),
  .mem_wdata_o  (mem_wdata_o),
  .mem_be_o     (mem_be_o),
  .load_data_o  (load_data_o),
  .misalign_o   (misalign_o)
);

// File: tb/be_lane_unit_tb.sv
module be_lane_unit_tb;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic [1:0]    size;
  logic          zext;
  logic [31:0]   sdata, rdata;
  logic [31:0]   wdata, ldata;
  logic [3:0]    be;
  logic          mis;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  be_lane_unit #(.ADDR_W(AW)) u_dut (
    .addr_i       (addr),
    .size_i       (size),
    .zero_ext_i   (zext),
    .store_data_i (sdata),
    .mem_wdata_o  (wdata),
    .mem_be_o     (be),
    .mem_rdata_i  (rdata),
    .load_data_o  (ldata),
    .misalign_o   (mis)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d size=%0d actual=%h expected=%h", req, addr, size, act, exp);
    end
  endtask

  function automatic logic e_mis(input logic [1:0] o, input logic [1:0] s);
    return (s == 2'd3) || (s == 2'd1 && o[0]) || (s == 2'd2 && o != 2'd0);
  endfunction

  function automatic logic [3:0] e_be(input logic [1:0] o, input logic [1:0] s);
    if (e_mis(o, s)) return 4'b0000;
    case (s)
      2'd0:    return 4'b1000 >> o;
      2'd1:    return (o == 2'd0) ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] e_wd(input logic [31:0] d, input logic [1:0] s);
    case (s)
      2'd0:    return {d[7:0], d[7:0], d[7:0], d[7:0]};
      2'd1:    return {d[15:0], d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] e_ld(input logic [31:0] r, input logic [1:0] o,
                                       input logic [1:0] s, input logic z);
    logic [31:0] v;
    if (e_mis(o, s)) return 32'd0;
    case (s)
      2'd0: begin
        v = (r >> (8 * (3 - o))) & 32'hFF;
        if (!z && v[7]) v = v | 32'hFFFF_FF00;
      end
      2'd1: begin
        v = (o == 2'd0) ? {16'd0, r[31:16]} : {16'd0, r[15:0]};
        if (!z && v[15]) v = v | 32'hFFFF_0000;
      end
      default: v = r;
    endcase
    return v;
  endfunction

  task automatic apply(input logic [AW-1:0] a, input logic [1:0] s, input logic z,
                       input logic [31:0] d, input logic [31:0] r);
    @(negedge clk);
    addr = a; size = s; zext = z; sdata = d; rdata = r;
    #1;
  endtask

  task automatic t_idle();
    apply('0, 2'd0, 1'b0, 32'd0, 32'd0);
    check("R2 idle enable", {28'd0, be}, 32'h8);
    check("R1 idle misalign", {31'd0, mis}, 32'd0);
    check("R5 idle wdata", wdata, 32'd0);
    check("R6 idle load", ldata, 32'd0);
  endtask

  task automatic t_store_sweep(input logic [31:0] d);
    for (int a = 0; a < (1 << AW); a++) begin
      for (int s = 0; s < 4; s++) begin
        logic [1:0] o;
        o = 2'(a);
        apply(AW'(a), 2'(s), 1'b0, d, 32'd0);
        check("R1 misalign", {31'd0, mis}, {31'd0, e_mis(o, 2'(s))});
        if (e_mis(o, 2'(s)))
          check("R4 enable", {28'd0, be}, {28'd0, e_be(o, 2'(s))});
        else if (s == 0)
          check("R2 enable", {28'd0, be}, {28'd0, e_be(o, 2'(s))});
        else
          check("R3 enable", {28'd0, be}, {28'd0, e_be(o, 2'(s))});
        check("R5 wdata", wdata, e_wd(d, 2'(s)));
        if (a >= 4)
          check("R12 upper address", {27'd0, mis, be}, {27'd0, e_mis(o, 2'(s)), e_be(o, 2'(s))});
      end
    end
  endtask

  task automatic t_load_sweep(input logic [31:0] r);
    for (int a = 0; a < (1 << AW); a++) begin
      for (int s = 0; s < 4; s++) begin
        for (int z = 0; z < 2; z++) begin
          logic [1:0] o;
          logic [31:0] ex;
          o  = 2'(a);
          ex = e_ld(r, o, 2'(s), 1'(z));
          apply(AW'(a), 2'(s), 1'(z), 32'hDEAD_BEEF, r);
          if (e_mis(o, 2'(s))) check("R11 misaligned load", ldata, ex);
          else if (s == 2) check("R8 word load", ldata, ex);
          else begin
            if (s == 0) check("R6 byte lane", {24'd0, ldata[7:0]}, {24'd0, ex[7:0]});
            else        check("R7 half lane", {16'd0, ldata[15:0]}, {16'd0, ex[15:0]});
            if (z == 1) check("R10 zero extend", ldata, ex);
            else        check("R9 sign extend", ldata, ex);
          end
        end
      end
    end
  endtask

  task automatic t_same_cycle();
    apply(AW'(1), 2'd0, 1'b0, 32'd0, 32'h0080_0000);
    check("R12 same cycle a", ldata, 32'hFFFF_FF80);
    rdata = 32'h007F_0000;
    #1;
    check("R12 same cycle b", ldata, 32'h0000_007F);
    sdata = 32'h1234_56AB;
    #1;
    check("R12 same cycle c", wdata, 32'hABAB_ABAB);
  endtask

  initial begin
    addr = '0; size = '0; zext = 1'b0; sdata = '0; rdata = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_store_sweep(32'hA5C3_7E81);
    t_store_sweep(32'h0F00_FF7F);
    t_load_sweep(32'h80FF_7F01);
    t_load_sweep(32'h7F01_8000);
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=below limit", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule